// File: doc/BRIEF.md
# Extended Condition-Register Bit Access Unit

This block holds a condition-register file of 32 four-bit fields (128 condition bits). Callers address single bits with a legacy 5-bit condition-bit operand. They widen its reach with a small extension value. The operand's upper part picks one of eight base fields and its lower part picks a bit. Both are numbered in big-endian order, so operand value 0 names the most significant bit of the highest base field. The extension value, together with a vector/scalar flag carried in its own lowest bit, moves that base field into one of 32 extended fields.

There is one combinational bit-read port and one bit-write port. The write port updates a single bit on the rising clock edge. Each port has its own operand, extension value and width flag. The flag selects whether all three extension bits are used or only the lower two. A third port returns a whole field, addressed directly by its 5-bit extended index, so the effect of writes can be observed.

Top module: `crx_bit_unit`

## Requirements
- R1: After reset every one of the 32 fields reads 4'b0000.
- R2: For operand `op`, the base field is 7 − op[4:2] and the bit within the field is 3 − op[1:0]. Bit 3 of a field is its most significant bit on the field port.
- R3: With the width flag at 1, the specifier is ext[2:0] as given, and ext[0] = 1 selects vector mode.
- R4: In vector mode the extended field index is base × 4 + ext[2:1] (specifier bits 2:1 as a 2-bit number).
- R5: In scalar mode the extended field index is base + 8 × ext[2:1].
- R6: With the width flag at 0, the specifier is {ext[1:0], 0}: always scalar, index = base + 8 × ext[1:0], and ext[2] has no effect.
- R7: A write with enable high sets the addressed bit to the write data on the rising clock edge. All 127 other bits keep their values.
- R8: With write enable low no bit changes, whatever the other write inputs are.
- R9: A read in the same cycle as a write to the same bit returns the value stored before that edge. The new value appears from the next cycle on.
- R10: The field port returns the 4 bits of the field whose 5-bit extended index is given, combinationally.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_opnd | input | 5 | Read port legacy condition-bit operand |
| rd_ext | input | 3 | Read port extension value |
| rd_ext3 | input | 1 | Read port width flag: 1 = 3-bit extension, 0 = 2-bit |
| rd_bit | output | 1 | Addressed condition bit |
| wr_en | input | 1 | Write enable |
| wr_opnd | input | 5 | Write port legacy condition-bit operand |
| wr_ext | input | 3 | Write port extension value |
| wr_ext3 | input | 1 | Write port width flag |
| wr_data | input | 1 | Value to store |
| fld_idx | input | 5 | Extended field index for the field port |
| fld_val | output | 4 | Field contents, bit 3 most significant |

## Verification
A bit read and a bit write can land on the same condition bit in one cycle. The same can happen between a write and the field port. The bench provokes this by driving identical, or aliasing, operand/extension triples on both ports in one cycle, while writing the inverse of the stored value. It expects the read to return the old value in that cycle and the new value in the following cycle. Aliasing covers cases such as a 2-bit-mode address that equals a scalar 3-bit-mode address. Random mixes of both modes compare every read against a bench-side model that is updated only after the edge.

// File: rtl/crx_bit_unit.sv
module crx_bit_unit #(
  parameter int FLD_W = 4,
  parameter int N_FLD = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] rd_opnd,
  input  logic [2:0] rd_ext,
  input  logic       rd_ext3,
  output logic       rd_bit,
  input  logic       wr_en,
  input  logic [4:0] wr_opnd,
  input  logic [2:0] wr_ext,
  input  logic       wr_ext3,
  input  logic       wr_data,
  input  logic [4:0] fld_idx,
  output logic [3:0] fld_val
);
  localparam int NBITS = FLD_W * N_FLD;
  localparam int PW    = $clog2(NBITS);

  function automatic logic [PW-1:0] bit_pos(input logic [4:0] op,
                                            input logic [2:0] ext,
                                            input logic       ext3);
    logic [2:0] spec, base;
    logic [1:0] bsel;
    logic [4:0] idx;
    spec = ext3 ? ext : {ext[1:0], 1'b0};
    base = 3'd7 - op[4:2];
    bsel = 2'd3 - op[1:0];
    idx  = spec[0] ? {base, spec[2:1]} : {spec[2:1], base};
    return PW'({idx, bsel});
  endfunction

  logic [NBITS-1:0] crf;
  logic [PW-1:0]    rd_pos, wr_pos;

  assign rd_pos  = bit_pos(rd_opnd, rd_ext, rd_ext3);
  assign wr_pos  = bit_pos(wr_opnd, wr_ext, wr_ext3);
  assign rd_bit  = crf[rd_pos];
  assign fld_val = crf[{fld_idx, 2'b00} +: 4];

  always_ff @(posedge clk) begin
    if (!rst_n)     crf <= '0;
    else if (wr_en) crf[wr_pos] <= wr_data;
  end
endmodule

// File: rtl/crx_bit_unit_chk.sv
module crx_bit_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] rd_opnd,
  input logic [2:0] rd_ext,
  input logic       rd_ext3,
  input logic       rd_bit,
  input logic       wr_en,
  input logic [4:0] wr_opnd,
  input logic [2:0] wr_ext,
  input logic       wr_ext3,
  input logic       wr_data,
  input logic [4:0] fld_idx,
  input logic [3:0] fld_val
);
  logic same_addr;
  assign same_addr = (rd_opnd == wr_opnd) && (rd_ext == wr_ext) && (rd_ext3 == wr_ext3);

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> fld_val == 4'b0000);

  a_r7_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && same_addr) |=>
      (($stable(rd_opnd) && $stable(rd_ext) && $stable(rd_ext3)) |-> rd_bit == $past(wr_data)));

  a_r7_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ($stable(fld_idx) |-> $countones(fld_val ^ $past(fld_val)) <= 1));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(fld_idx) |-> $stable(fld_val)));
endmodule

bind crx_bit_unit crx_bit_unit_chk u_chk (.*);

// File: tb/tb_crx_bit_unit.sv
module tb_crx_bit_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] rd_opnd = '0, wr_opnd = '0, fld_idx = '0;
  logic [2:0] rd_ext = '0, wr_ext = '0;
  logic rd_ext3 = 1'b0, wr_ext3 = 1'b0, wr_en = 1'b0, wr_data = 1'b0;
  logic rd_bit;
  logic [3:0] fld_val;

  always #10 clk = ~clk;

  crx_bit_unit dut (.*);

  typedef struct {
    bit         is_fld;
    logic [3:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  logic [127:0] model = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic int pos(input logic [4:0] op, input logic [2:0] ext, input logic ext3);
    int base, b, hi, idx;
    bit vec;
    base = 7 - int'(op[4:2]);
    b    = 3 - int'(op[1:0]);
    if (ext3) begin hi = int'(ext[2:1]); vec = ext[0]; end
    else      begin hi = int'(ext[1:0]); vec = 1'b0;   end
    idx = vec ? base * 4 + hi : base + 8 * hi;
    return idx * 4 + b;
  endfunction

  task automatic cyc(input logic [4:0] rop, input logic [2:0] rex, input logic rx3,
                     input logic we, input logic [4:0] wop, input logic [2:0] wex,
                     input logic wx3, input logic wd, input logic [4:0] fi, input string tag);
    item_t it;
    @(negedge clk);
    rd_opnd = rop; rd_ext = rex; rd_ext3 = rx3;
    wr_en = we; wr_opnd = wop; wr_ext = wex; wr_ext3 = wx3; wr_data = wd;
    fld_idx = fi;
    it.is_fld = 0; it.exp = {3'b0, model[pos(rop, rex, rx3)]}; it.tag = tag; q.push_back(it);
    it.is_fld = 1; it.exp = model[{fi, 2'b00} +: 4];            it.tag = tag; q.push_back(it);
    @(posedge clk);
    if (we) model[pos(wop, wex, wx3)] = wd;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (q.size() > 0) begin
        item_t it;
        logic [3:0] act;
        it = q.pop_front();
        act = it.is_fld ? fld_val : {3'b0, rd_bit};
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s %s: actual=%b expected=%b", it.tag, it.is_fld ? "field" : "bit", act, it.exp);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: every field zero after reset
    for (int f = 0; f < 32; f++) cyc(5'(f), 3'(f), f[0], 0, 0, 0, 0, 0, 5'(f), "R1");
    // R2/R5: operand 0, scalar spec hi=3 -> field 31 bit 3
    cyc(0, 3'b110, 1, 1, 0, 3'b110, 1, 1, 31, "R9");
    cyc(0, 3'b110, 1, 0, 0, 0, 0, 0, 31, "R2 R5");
    // R6: 2-bit mode ext=11 with ext[2] set aliases the same bit
    cyc(0, 3'b111, 0, 0, 0, 0, 0, 0, 31, "R6");
    cyc(0, 3'b011, 0, 0, 0, 0, 0, 0, 31, "R6");
    // R3/R4: vector mode, op=00011 -> base 7 bit 0, hi=2 -> field 30
    cyc(5'b00011, 3'b101, 1, 1, 5'b00011, 3'b101, 1, 1, 30, "R9");
    cyc(5'b00011, 3'b101, 1, 0, 0, 0, 0, 0, 30, "R3 R4");
    // R2: op=11111 -> base 0 bit 0, vector hi=0 -> field 0
    cyc(5'b11111, 3'b001, 1, 1, 5'b11111, 3'b001, 1, 1, 0, "R2");
    cyc(5'b11100, 3'b001, 1, 1, 5'b11111, 3'b001, 1, 1, 0, "R2 R10");
    // R8: enable low with active-looking inputs
    cyc(0, 3'b110, 1, 0, 0, 3'b110, 1, 0, 31, "R8");
    cyc(0, 3'b110, 1, 0, 0, 3'b110, 1, 0, 31, "R8");
    // R9: clear a set bit, read same cycle and next
    cyc(0, 3'b110, 1, 1, 0, 3'b110, 1, 0, 31, "R9");
    cyc(0, 3'b110, 1, 0, 0, 0, 0, 0, 31, "R9 R7");
    // R7/R10: random mix of modes
    for (int i = 0; i < 400; i++) begin
      logic [4:0] a, b, f;
      logic [2:0] ea, eb;
      logic ma, mb, we, d;
      a = 5'($urandom); b = 5'($urandom); f = 5'($urandom);
      ea = 3'($urandom); eb = 3'($urandom);
      ma = 1'($urandom); mb = 1'($urandom); we = 1'($urandom); d = 1'($urandom);
      if (i % 4 == 0) begin a = b; ea = eb; ma = mb; d = ~model[pos(b, eb, mb)]; end
      cyc(a, ea, ma, we, b, eb, mb, d, f, "R7 R10");
    end
    for (int f = 0; f < 32; f++) cyc(5'(f), 3'(f), 1, 0, 0, 0, 0, 0, 5'(f), "R10");
    @(negedge clk); #8;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule